// File: doc/BRIEF.md
# Serial Debug Memory Access Port

This block is a slave synchronous serial port. An external debug host uses it to read and write a 16-bit-wide on-chip code RAM while the CPU keeps running. The host drives a slow serial clock and a data line. The block returns read data on a serial output and drives an active-low busy line. The serial clock is not used as a clock. It is synchronized into the system clock domain and edge-detected there, so the serial clock must run at no more than half the system clock.

Every transaction starts with a command byte and a 16-bit address. A write then carries one or two data bytes. A read makes the block fetch the data and shift back one or two bytes. The RAM is reached through a valid/ready request channel. While a request is outstanding the block holds busy low and ignores the serial clock. A command bit can raise a one-cycle interrupt request towards the CPU, which runs a monitor routine.

Top module: `dbg_serial_port`

## Requirements
- R1: Serial input is taken 8 bits per byte, most significant bit first. Each bit is the data line value at a rising serial clock edge, detected after a two-stage synchronizer in the system clock domain.
- R2: A transaction is: command byte, address high byte, address low byte. A write then adds data: one byte for a byte access, or two bytes with the high byte first for a word access.
- R3: Command byte fields are: bit 7 = 1 write / 0 read, bit 6 = 1 word / 0 byte, bit 5 = interrupt request. Bits 4:0 are ignored.
- R4: busy_n goes low one system clock after the synchronized rising edge that completes the last address bit (read) or the last data bit (write). It stays low until the RAM access completes. Serial clock edges seen while busy_n is low shift no data.
- R5: The RAM request obeys back-pressure. mem_req_valid stays high, with mem_addr, mem_we, mem_be and mem_wdata stable, until a cycle in which mem_req_ready is high. Read data is taken from mem_rdata in that same cycle.
- R6: Lane selection: a word access uses mem_be=11. A byte access with address bit 0 = 0 uses mem_be=01 and lane [7:0]. With address bit 0 = 1 it uses mem_be=10 and lane [15:8]. Byte write data is placed on both lanes.
- R7: Addresses at or above 3072 issue no RAM request. Reads of such addresses return 0, and writes to them are dropped.
- R8: Read data is shifted out most significant bit first: 8 bits for a byte read, or 16 bits with the high byte first for a word read. Each rising serial edge after busy is released moves ser_dout to the next bit, one system clock after the synchronized edge.
- R9: A command byte with bit 5 set produces exactly one single-cycle pulse on irq_req. Other commands produce none.
- R10: ser_dout holds its last value whenever the block is not shifting read data.
- R11: A synchronous active-high reset returns the block to waiting for a command. It sets busy_n=1, ser_dout=0 and mem_req_valid=0, and clears partial bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host serial clock, at most half of clk |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial read data to host |
| busy_n | output | 1 | Low while a RAM access is in progress |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| mem_req_valid | output | 1 | RAM request valid |
| mem_req_ready | input | 1 | RAM accepts request; read data valid |
| mem_addr | output | 16 | Byte address of the access |
| mem_we | output | 1 | 1 = write |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_req_ready |

## Verification
The bench toggles the serial clock while the RAM holds off its acknowledge. A design that shifts during busy would misframe the next command and read back wrong data. The bench also drives the boundary between the last valid word (3070) and the first invalid address (3072), including 0xFFFF. A missing range check would show up as a RAM handshake or as nonzero read data. Byte accesses to odd and even addresses expose swapped lanes or wrong enables. Further checks cover an interrupt command, reserved command bits set to ones, a reset in the middle of an address, and a write following a read. These catch stray interrupts, leaked partial bytes and a ser_dout that does not hold its value.

// File: rtl/dbgsp_pkg.sv
package dbgsp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int CMD_WR  = 7;
  localparam int CMD_WD  = 6;
  localparam int CMD_IRQ = 5;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADH, ST_ADL, ST_WDAT, ST_ACC, ST_RD
  } dbgsp_state_t;
endpackage

// File: rtl/dbgsp_edge.sv
module dbgsp_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_raw,
  input  logic sdi_raw,
  output logic rise,
  output logic sdi_s
);
  logic [SYNC:0]   clk_pipe;
  logic [SYNC-1:0] sdi_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe <= '0;
      sdi_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[SYNC-1:0], sclk_raw};
      sdi_pipe <= {sdi_pipe[SYNC-2:0], sdi_raw};
    end
  end

  assign rise  = clk_pipe[SYNC-1] & ~clk_pipe[SYNC];
  assign sdi_s = sdi_pipe[SYNC-1];
endmodule

// File: rtl/dbgsp_rx.sv
module dbgsp_rx
  import dbgsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (shift_en) begin
      sh  <= {sh[BYTE_W-2:0], bit_in};
      cnt <= cnt + 1'b1;
    end
  end

  assign byte_done = shift_en && (cnt == CW'(BYTE_W - 1));
  assign byte_val  = {sh[BYTE_W-2:0], bit_in};
endmodule

// File: rtl/dbgsp_tx.sv
module dbgsp_tx
  import dbgsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              shift_en,
  output logic              sdo
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else if (load) begin
      sh <= load_val;
    end else if (shift_en) begin
      sdo <= sh[WORD_W-1];
      sh  <= {sh[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dbgsp_ctrl.sv
module dbgsp_ctrl
  import dbgsp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 3072
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_en,
  output logic              tx_en,
  output logic              tx_load,
  output logic [WORD_W-1:0] tx_val,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rdata,
  output logic              busy_n,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_BYTES);
  localparam int RCW = $clog2(WORD_W + 1);

  dbgsp_state_t      st;
  logic              c_wr, c_wd;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdat_q;
  logic              second;
  logic [RCW-1:0]    rd_left;
  logic              irq_q;
  logic              in_range, done;
  logic [WORD_W-1:0] rd_word;
  logic [BYTE_W-1:0] rd_lane;

  assign in_range = addr_q < LIMIT;
  assign done     = (st == ST_ACC) && (!in_range || req_ready);
  assign rx_en    = rise && (st == ST_CMD || st == ST_ADH || st == ST_ADL || st == ST_WDAT);
  assign tx_en    = rise && (st == ST_RD);
  assign rd_word  = in_range ? rdata : '0;
  assign rd_lane  = addr_q[0] ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
  assign tx_load  = done && !c_wr;
  assign tx_val   = c_wd ? rd_word : {rd_lane, {BYTE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_CMD;
      c_wr    <= 1'b0;
      c_wd    <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      second  <= 1'b0;
      rd_left <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st)
        ST_CMD: if (rx_done) begin
          c_wr  <= rx_byte[CMD_WR];
          c_wd  <= rx_byte[CMD_WD];
          irq_q <= rx_byte[CMD_IRQ];
          st    <= ST_ADH;
        end
        ST_ADH: if (rx_done) begin
          addr_q[ADDR_W-1:BYTE_W] <= rx_byte[ADDR_W-BYTE_W-1:0];
          st <= ST_ADL;
        end
        ST_ADL: if (rx_done) begin
          addr_q[BYTE_W-1:0] <= rx_byte;
          second <= 1'b0;
          st <= c_wr ? ST_WDAT : ST_ACC;
        end
        ST_WDAT: if (rx_done) begin
          if (c_wd && !second) begin
            wdat_q[WORD_W-1:BYTE_W] <= rx_byte;
            second <= 1'b1;
          end else begin
            if (c_wd) wdat_q[BYTE_W-1:0] <= rx_byte;
            else      wdat_q <= {rx_byte, rx_byte};
            st <= ST_ACC;
          end
        end
        ST_ACC: if (done) begin
          st      <= c_wr ? ST_CMD : ST_RD;
          rd_left <= c_wd ? RCW'(WORD_W) : RCW'(BYTE_W);
        end
        ST_RD: if (tx_en) begin
          rd_left <= rd_left - 1'b1;
          if (rd_left == RCW'(1)) st <= ST_CMD;
        end
        default: st <= ST_CMD;
      endcase
    end
  end

  assign req_valid = (st == ST_ACC) && in_range;
  assign addr      = addr_q;
  assign we        = c_wr;
  assign be        = c_wd ? 2'b11 : (addr_q[0] ? 2'b10 : 2'b01);
  assign wdata     = wdat_q;
  assign busy_n    = (st != ST_ACC);
  assign irq       = irq_q;
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dbgsp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int MEM_BYTES   = 3072,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              busy_n,
  output logic              irq_req,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic              rise, sdi_s, rx_en, rx_done, tx_en, tx_load;
  logic [BYTE_W-1:0] rx_byte;
  logic [WORD_W-1:0] tx_val;

  dbgsp_edge #(.SYNC(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .sclk_raw(ser_clk), .sdi_raw(ser_din),
    .rise(rise), .sdi_s(sdi_s)
  );

  dbgsp_rx rx_i (
    .clk(clk), .rst(rst), .shift_en(rx_en), .bit_in(sdi_s),
    .byte_done(rx_done), .byte_val(rx_byte)
  );

  dbgsp_tx tx_i (
    .clk(clk), .rst(rst), .load(tx_load), .load_val(tx_val),
    .shift_en(tx_en), .sdo(ser_dout)
  );

  dbgsp_ctrl #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) ctrl_i (
    .clk(clk), .rst(rst), .rise(rise), .rx_done(rx_done), .rx_byte(rx_byte),
    .rx_en(rx_en), .tx_en(tx_en), .tx_load(tx_load), .tx_val(tx_val),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .addr(mem_addr),
    .we(mem_we), .be(mem_be), .wdata(mem_wdata), .rdata(mem_rdata),
    .busy_n(busy_n), .irq(irq_req)
  );
endmodule

// File: rtl/dbg_serial_port_chk.sv
module dbg_serial_port_chk #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 3072
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_dout,
  input logic              busy_n,
  input logic              irq_req,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [1:0]        mem_be,
  input logic [15:0]       mem_wdata
);
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata));

  a_r4_busy_during_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !busy_n);

  a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  a_r7_req_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_addr < ADDR_W'(MEM_BYTES));

  a_r6_byte_lane: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_be != 2'b11 |-> mem_be == (mem_addr[0] ? 2'b10 : 2'b01));

  a_r10_dout_hold_busy: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> $stable(ser_dout));

  a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy_n && !mem_req_valid && !ser_dout);
endmodule

bind dbg_serial_port dbg_serial_port_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) chk_i (
  .clk(clk), .rst(rst), .ser_dout(ser_dout), .busy_n(busy_n), .irq_req(irq_req),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata)
);

// File: tb/dbg_serial_port_tb_top.sv
module dbg_serial_port_tb_top;
  localparam int HP = 6;
  localparam int NV = 13;
  // entry: cmd[55:48] addr[47:32] wdata[31:16] expected read[15:0]
  localparam logic [55:0] VEC [NV] = '{
    {8'hC0, 16'h0010, 16'hA55A, 16'h0000},
    {8'h40, 16'h0010, 16'h0000, 16'hA55A},
    {8'h80, 16'h0021, 16'h003C, 16'h0000},
    {8'h80, 16'h0020, 16'h00C3, 16'h0000},
    {8'h40, 16'h0020, 16'h0000, 16'h3CC3},
    {8'h00, 16'h0021, 16'h0000, 16'h003C},
    {8'h00, 16'h0010, 16'h0000, 16'h005A},
    {8'hC0, 16'h0BFE, 16'h1234, 16'h0000},
    {8'h40, 16'h0BFE, 16'h0000, 16'h1234},
    {8'h40, 16'h0C00, 16'h0000, 16'h0000},
    {8'h80, 16'h0C00, 16'h00FF, 16'h0000},
    {8'h00, 16'hFFFF, 16'h0000, 16'h0000},
    {8'h5F, 16'h0010, 16'h0000, 16'hA55A}
  };

  logic clk = 1'b0, rst = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, busy_n, irq_req, mem_req_valid, mem_req_ready, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;

  always #2 clk = ~clk;

  dbg_serial_port dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout),
    .busy_n(busy_n), .irq_req(irq_req), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model with programmable acknowledge latency
  logic [15:0] ram [0:1535];
  int lat = 2, wcnt = 0, hs_cnt = 0, irq_cnt = 0, irq_wide = 0;
  logic rdy = 1'b0, irq_prev = 1'b0;
  logic [15:0] hs_addr, hs_wdata;
  logic [1:0]  hs_be;
  assign mem_req_ready = rdy;
  assign mem_rdata = rdy ? ram[mem_addr[11:1]] : 16'hDEAD;

  initial for (int i = 0; i < 1536; i++) ram[i] = 16'h0000;

  always @(posedge clk) begin
    rdy <= 1'b0;
    if (mem_req_valid && !rdy) begin
      if (wcnt >= lat) begin rdy <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end
    if (mem_req_valid && rdy) begin
      hs_cnt <= hs_cnt + 1;
      hs_addr <= mem_addr; hs_be <= mem_be; hs_wdata <= mem_wdata;
      if (mem_we) begin
        if (mem_be[0]) ram[mem_addr[11:1]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) ram[mem_addr[11:1]][15:8] <= mem_wdata[15:8];
      end
    end
    irq_prev <= irq_req;
    if (irq_req) irq_cnt <= irq_cnt + 1;
    if (irq_req && irq_prev) irq_wide <= irq_wide + 1;
  end

  int total = 0, bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      ser_din = b[i]; ser_clk = 1'b0; wait_n(HP);
      ser_clk = 1'b1; wait_n(HP);
    end
  endtask

  task automatic recv_bits(input int n, output logic [15:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b0; wait_n(HP);
      ser_clk = 1'b1; wait_n(HP);
      v = {v[14:0], ser_dout};
    end
  endtask

  task automatic wait_idle();
    wait_n(10);
    while (busy_n !== 1'b1) wait_n(1);
  endtask

  task automatic xact(input logic [7:0] cmd, input logic [15:0] a,
                      input logic [15:0] d, output logic [15:0] rd);
    send_byte(cmd); send_byte(a[15:8]); send_byte(a[7:0]);
    if (cmd[7]) begin
      if (cmd[6]) send_byte(d[15:8]);
      send_byte(d[7:0]);
    end
    wait_idle();
    rd = '0;
    if (!cmd[7]) recv_bits(cmd[6] ? 16 : 8, rd);
  endtask

  initial begin
    wait_n(200000);
    bad++;
    $display("FAIL watchdog act=%0d exp=done", total);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic held;
    int h0;
    wait_n(5);
    // R11: reset state
    chk("R11 busy_n", busy_n, 1); chk("R11 dout", ser_dout, 0);
    chk("R11 req_valid", mem_req_valid, 0); chk("R9 irq idle", irq_req, 0);
    rst = 1'b0; wait_n(3);

    for (int k = 0; k < NV; k++) begin
      logic [7:0]  c;
      logic [15:0] a, d, e;
      logic        inr;
      c = VEC[k][55:48]; a = VEC[k][47:32]; d = VEC[k][31:16]; e = VEC[k][15:0];
      inr = a < 16'd3072;
      h0 = hs_cnt;
      xact(c, a, d, rd);
      chk("R7 R5 handshake count", hs_cnt - h0, inr ? 1 : 0);
      if (inr) begin
        chk("R2 R1 address", hs_addr, a);
        chk("R6 lanes", hs_be, c[6] ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
      end
      if (c[7] && inr)
        chk("R2 R6 write data", hs_wdata, c[6] ? d : {d[7:0], d[7:0]});
      if (!c[7]) chk("R8 R3 R7 read data", rd, e);
    end
    chk("R9 no irq without bit5", irq_cnt, 0);

    // R9: interrupt request command
    xact(8'h60, 16'h0010, 16'h0, rd);
    chk("R9 one irq pulse", irq_cnt, 1);
    chk("R9 pulse width", irq_wide, 0);
    chk("R9 read with irq", rd, 16'hA55A);

    // R4: serial edges during busy are ignored
    lat = 40;
    send_byte(8'hC0); send_byte(8'h00); send_byte(8'h30);
    send_byte(8'hBE); send_byte(8'hEF);
    chk("R4 busy asserted", busy_n, 0);
    ser_din = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ser_clk = 1'b0; wait_n(2); ser_clk = 1'b1; wait_n(2);
    end
    chk("R4 still busy", busy_n, 0);
    wait_idle();
    lat = 2;
    xact(8'h40, 16'h0030, 16'h0, rd);
    chk("R4 framing after busy edges", rd, 16'hBEEF);

    // R10: dout holds across a write
    held = ser_dout;
    chk("R8 last bit", held, 1'b1);
    xact(8'hC0, 16'h0040, 16'h0000, rd);
    chk("R10 dout held", ser_dout, held);

    // R11: reset mid-address clears partial state
    send_byte(8'h40); send_byte(8'h00);
    ser_din = 1'b1; ser_clk = 1'b0; wait_n(HP); ser_clk = 1'b1; wait_n(HP);
    ser_clk = 1'b0; wait_n(HP);
    rst = 1'b1; wait_n(3);
    chk("R11 dout after reset", ser_dout, 0);
    chk("R11 busy after reset", busy_n, 1);
    rst = 1'b0; wait_n(3);
    xact(8'h40, 16'h0010, 16'h0, rd);
    chk("R11 clean frame after reset", rd, 16'hA55A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule